// File: doc/BRIEF.md
# Stratum Termination Controller

This block governs how one core moves through repeated global execution strata. While the core is in its execute phase, the block counts either retired instructions or cycle ticks, depending on the selected mode, and watches for synchronization, atomic read-modify-write, write-buffer exhaustion and pending interrupts. When a termination condition is met it ends the stratum. It then requests the global barrier and waits for the barrier release. Next it holds the core in a publish phase until the core reports that the flush is done. A second barrier round follows before execution resumes in a new, numbered stratum.

Because the termination condition depends only on architectural events in the two deterministic modes, stratum boundaries repeat from run to run. The conventional mode counts cycles instead, which balances load better but gives up that repeatability. Interrupts are taken only when a new stratum opens. Each delivery is reported together with its vector and the stratum number, so that it can be logged.

Top module: `stratum_ctrl`

## Requirements
- R1: After reset the phase is EXECUTE (code 0), the stratum number is 0, and bar_req, end_cause and irq_take are all 0.
- R2: In mode 0 (and mode 3, which behaves the same), the stratum ends in the execute cycle in which the accumulated retired-instruction count, including that cycle's retire_cnt, reaches or passes threshold. cyc_tick and wbuf_full have no effect in this mode.
- R3: In mode 1, the count is the number of execute cycles with cyc_tick high, and the stratum ends when that count reaches threshold. retire_cnt and wbuf_full have no effect in this mode.
- R4: In mode 2, the stratum ends on the instruction threshold as in R2, and also in any execute cycle with wbuf_full high.
- R5: In every mode, sync_ev or atomic_ev high in an execute cycle ends the stratum in that cycle. The phase reads WAIT_END (code 1) after the next clock edge.
- R6: When a stratum ends, one end is taken and end_cause latches a mask of every cause present in that cycle: bit 0 count threshold, bit 1 synchronization, bit 2 atomic, bit 3 write-buffer exhaustion. The mask holds until the next end.
- R7: bar_req is high in WAIT_END (1) and WAIT_PUB (3). A bar_go pulse moves WAIT_END to PUBLISH (2) and moves WAIT_PUB to EXECUTE (0). bar_go has no effect in EXECUTE or PUBLISH.
- R8: PUBLISH lasts until pub_done is high, then moves to WAIT_PUB. atomic_go is high throughout PUBLISH when end_cause bit 2 is set. pub_done has no effect outside PUBLISH.
- R9: The stratum number increments by one on each entry to EXECUTE and changes at no other time. The event count restarts from zero in every new stratum.
- R10: irq_take is high for exactly the first cycle of a new stratum if irq_pend was high at the moment of entry. irq_log_vec and irq_log_stratum then show the vector and the new stratum number. irq_take is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 unbounded deterministic, 1 conventional, 2 bounded deterministic, 3 as 0 |
| threshold | input | CNT_W | Stratum length in instructions or ticks |
| retire_cnt | input | RET_W | Instructions retired this cycle |
| cyc_tick | input | 1 | Cycle tick for conventional mode |
| sync_ev | input | 1 | Synchronization event |
| atomic_ev | input | 1 | Atomic read-modify-write reached |
| wbuf_full | input | 1 | Write buffer exhausted |
| irq_pend | input | 1 | Interrupt pending |
| irq_vec | input | VEC_W | Pending interrupt vector |
| bar_go | input | 1 | Barrier release pulse |
| pub_done | input | 1 | Publish flush finished |
| bar_req | output | 1 | Barrier request |
| phase | output | 2 | Current phase code |
| stratum | output | STR_W | Current stratum number |
| end_cause | output | 4 | Cause mask of the last end |
| atomic_go | output | 1 | Perform the atomic as the last store of publish |
| irq_take | output | 1 | Interrupt delivered this cycle |
| irq_log_vec | output | VEC_W | Vector of the delivered interrupt |
| irq_log_stratum | output | STR_W | Stratum in which it was delivered |

## Verification
Every result is registered, so a termination cause applied in execute cycle c shows up as phase 1 and a new end_cause one edge later. The bench drives each cycle's inputs at the falling edge and reads the outputs 1 ns after the next rising edge. It therefore records the index of the first cycle after which the phase has left EXECUTE, and compares it with the cycle count computed from the threshold, rate and event position. A barrier release or pub_done applied in one cycle moves the phase at the following edge. The first cycle of a new stratum is checked for irq_take, and the cycle after it is checked for the pulse having dropped.

// File: rtl/stratum_ctrl.sv
module stratum_ctrl #(
  parameter int CNT_W = 16,
  parameter int RET_W = 2,
  parameter int STR_W = 16,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] threshold,
  input  logic [RET_W-1:0] retire_cnt,
  input  logic             cyc_tick,
  input  logic             sync_ev,
  input  logic             atomic_ev,
  input  logic             wbuf_full,
  input  logic             irq_pend,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             bar_go,
  input  logic             pub_done,
  output logic             bar_req,
  output logic [1:0]       phase,
  output logic [STR_W-1:0] stratum,
  output logic [3:0]       end_cause,
  output logic             atomic_go,
  output logic             irq_take,
  output logic [VEC_W-1:0] irq_log_vec,
  output logic [STR_W-1:0] irq_log_stratum
);
  localparam logic [1:0] PH_EXEC = 2'd0, PH_WEND = 2'd1, PH_PUB = 2'd2, PH_WPUB = 2'd3;
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [SUM_W-1:0] cnt_nxt;
  logic [3:0]       hit;

  wire by_cycles = (mode == 2'd1);
  wire bounded   = (mode == 2'd2);

  assign cnt_nxt = {1'b0, cnt} + (by_cycles ? SUM_W'(cyc_tick) : SUM_W'(retire_cnt));
  assign hit     = {bounded & wbuf_full, atomic_ev, sync_ev, cnt_nxt >= {1'b0, threshold}};

  assign bar_req   = (phase == PH_WEND) || (phase == PH_WPUB);
  assign atomic_go = (phase == PH_PUB) && end_cause[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase           <= PH_EXEC;
      cnt             <= '0;
      stratum         <= '0;
      end_cause       <= '0;
      irq_take        <= 1'b0;
      irq_log_vec     <= '0;
      irq_log_stratum <= '0;
    end else begin
      irq_take <= 1'b0;
      case (phase)
        PH_EXEC:
          if (|hit) begin
            phase     <= PH_WEND;
            end_cause <= hit;
            cnt       <= '0;
          end else begin
            cnt <= cnt_nxt[CNT_W-1:0];
          end
        PH_WEND: if (bar_go) phase <= PH_PUB;
        PH_PUB:  if (pub_done) phase <= PH_WPUB;
        default:
          if (bar_go) begin
            phase    <= PH_EXEC;
            cnt      <= '0;
            stratum  <= stratum + 1'b1;
            irq_take <= irq_pend;
            if (irq_pend) begin
              irq_log_vec     <= irq_vec;
              irq_log_stratum <= stratum + 1'b1;
            end
          end
      endcase
    end
  end
endmodule

// File: rtl/stratum_ctrl_chk.sv
module stratum_ctrl_chk #(
  parameter int STR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             bar_go,
  input logic [1:0]       phase,
  input logic [STR_W-1:0] stratum,
  input logic [3:0]       end_cause,
  input logic             atomic_go,
  input logic             irq_take
);
  assert_exec_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd0 |=> phase == 2'd0 || phase == 2'd1);

  assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1 && !bar_go) |=> phase == 2'd1);

  assert_stratum_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0 && $past(phase) == 2'd3) |-> stratum == STR_W'($past(stratum) + 1'b1));

  assert_stratum_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase == 2'd0 && $past(phase) == 2'd3) |-> $stable(stratum));

  assert_irq_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (phase == 2'd0 && $past(phase) == 2'd3));

  assert_atomic_pub_R8: assert property (@(posedge clk) disable iff (!rst_n)
    atomic_go |-> phase == 2'd2);

  assert_cause_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1 && $past(phase) == 2'd0) |-> end_cause != 4'd0);

  assert_exhaust_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1 && $past(phase) == 2'd0 && end_cause[3]) |-> $past(mode) == 2'd2);
endmodule

bind stratum_ctrl stratum_ctrl_chk #(.STR_W(STR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .bar_go(bar_go), .phase(phase),
  .stratum(stratum), .end_cause(end_cause), .atomic_go(atomic_go), .irq_take(irq_take)
);

// File: tb/stratum_ctrl_bench.sv
module stratum_ctrl_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  mode = '0;
  logic [15:0] threshold = '1;
  logic [1:0]  retire_cnt = '0;
  logic        cyc_tick = 0, sync_ev = 0, atomic_ev = 0, wbuf_full = 0;
  logic        irq_pend = 0, bar_go = 0, pub_done = 0;
  logic [7:0]  irq_vec = '0;
  logic        bar_req, atomic_go, irq_take;
  logic [1:0]  phase;
  logic [15:0] stratum, irq_log_stratum;
  logic [3:0]  end_cause;
  logic [7:0]  irq_log_vec;

  stratum_ctrl u_stratum_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .threshold(threshold), .retire_cnt(retire_cnt),
    .cyc_tick(cyc_tick), .sync_ev(sync_ev), .atomic_ev(atomic_ev), .wbuf_full(wbuf_full),
    .irq_pend(irq_pend), .irq_vec(irq_vec), .bar_go(bar_go), .pub_done(pub_done),
    .bar_req(bar_req), .phase(phase), .stratum(stratum), .end_cause(end_cause),
    .atomic_go(atomic_go), .irq_take(irq_take), .irq_log_vec(irq_log_vec),
    .irq_log_stratum(irq_log_stratum)
  );

  int errs = 0, checks = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ev mask: 1 sync, 2 atomic, 4 write-buffer full
  localparam int NV = 11;
  localparam int T_MODE[NV] = '{0, 0, 1, 2, 0, 1, 2, 0, 3, 2, 2};
  localparam int T_THR [NV] = '{10, 10, 7, 20, 20, 9, 6, 5, 4, 0, 3};
  localparam int T_RATE[NV] = '{1, 3, 3, 1, 1, 0, 2, 0, 2, 1, 1};
  localparam int T_EV  [NV] = '{0, 0, 4, 4, 4, 1, 2, 1, 0, 0, 7};
  localparam int T_AT  [NV] = '{0, 0, 2, 5, 5, 4, 3, 8, 0, 0, 3};

  task automatic run(input int md, input int thr, input int rate, input int ev,
                     input int at, input bit irq, input int vec);
    int n_cnt, n, got, cause, start;
    bit appl;
    string req;
    if (md == 1) n_cnt = (thr == 0) ? 1 : thr;
    else if (rate == 0) n_cnt = 100000;
    else n_cnt = (thr == 0) ? 1 : (thr + rate - 1) / rate;
    appl = (ev & 3) != 0 || ((ev & 4) != 0 && md == 2);
    n = (appl && at < n_cnt) ? at : n_cnt;
    cause = (n_cnt == n) ? 1 : 0;
    if (at == n) begin
      if (ev & 1) cause |= 2;
      if (ev & 2) cause |= 4;
      if ((ev & 4) && md == 2) cause |= 8;
    end
    req = (appl && at == n) ? "R5" : (md == 1 ? "R3" : (md == 2 ? "R4" : "R2"));
    start = stratum;
    irq_pend = irq;
    irq_vec = 8'(vec);
    got = 0;
    for (int c = 1; c <= 200; c++) begin
      @(negedge clk);
      mode = 2'(md); threshold = 16'(thr); retire_cnt = 2'(rate); cyc_tick = 1'b1;
      sync_ev = (ev & 1) && c == at; atomic_ev = (ev & 2) && c == at;
      wbuf_full = (ev & 4) && c == at;
      bar_go = 1'b1; pub_done = 1'b1;
      @(posedge clk); #1;
      if (phase != 2'd0) begin got = c; break; end
    end
    @(negedge clk);
    threshold = '1; retire_cnt = 0; cyc_tick = 0; sync_ev = 0; atomic_ev = 0;
    wbuf_full = 0; bar_go = 0; pub_done = 0;
    chk(req, got, n);
    chk("R6", end_cause, cause);
    chk("R7", bar_req, 1);
    chk("R10", irq_take, 0);
    chk("R9", stratum, start);
    repeat (15) @(negedge clk);
    chk("R7", phase, 1);
    bar_go = 1;
    @(posedge clk); #1;
    chk("R7", phase, 2);
    chk("R8", atomic_go, (cause >> 2) & 1);
    @(negedge clk); bar_go = 0;
    repeat (3) @(negedge clk);
    chk("R8", phase, 2);
    pub_done = 1;
    @(posedge clk); #1;
    chk("R8", phase, 3);
    @(negedge clk); pub_done = 0;
    repeat (15) @(negedge clk);
    bar_go = 1;
    @(posedge clk); #1;
    chk("R7", phase, 0);
    chk("R9", stratum, start + 1);
    chk("R10", irq_take, irq);
    if (irq) begin
      chk("R10", irq_log_vec, vec);
      chk("R10", irq_log_stratum, start + 1);
    end
    @(negedge clk); bar_go = 0; irq_pend = 0;
    @(posedge clk); #1;
    chk("R10", irq_take, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", phase, 0);
    chk("R1", stratum, 0);
    chk("R1", bar_req, 0);
    chk("R1", end_cause, 0);
    chk("R1", irq_take, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", phase, 0);
    for (int i = 0; i < NV; i++)
      run(T_MODE[i], T_THR[i], T_RATE[i], T_EV[i], T_AT[i], (i % 3) == 1, 8'h40 + i);
    // directed: interrupt held through a whole stratum is taken once at the next entry
    run(2, 2, 1, 0, 0, 1'b1, 8'hA5);
    // directed: reset mid-stratum clears the stratum number
    @(negedge clk); mode = 0; threshold = 16'd50; retire_cnt = 1;
    repeat (3) @(negedge clk);
    rst_n = 0;
    @(posedge clk); #1;
    chk("R1", stratum, 0);
    chk("R1", end_cause, 0);
    @(negedge clk); rst_n = 1; threshold = '1; retire_cnt = 0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #2000000;
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule